// File: doc/BRIEF.md
# Standby Halt/Stop Controller

This block sequences low-power standby for a small controller core. When the core issues a halt strobe, the block captures a 4-bit release operand and a mode bit. It then stalls the core. In halt mode the clock keeps running. In stop mode the block also removes the oscillator enable. Registers and data memory outside the block keep their contents, because only instruction execution is held off.

While in standby, the block watches four release sources: the serial input pin, the key I/O lines, the key input lines and the completion of the burst timer. It resumes execution when the source picked by the operand meets the selected level. If stop mode is requested while the burst timer is still counting down, the oscillator stays enabled until the counter reaches zero. Pin inputs pass through a synchronizer before they are used. Each release produces a single-cycle wake pulse.

Top module: `stby_ctrl`

## Requirements
- R1: After reset, cpu_stall is 0, osc_en is 1 and wake_pulse is 0.
- R2: A halt_req sampled while running with stop_sel=0 raises cpu_stall at the next clock edge, and osc_en stays 1 for the whole standby.
- R3: A halt_req sampled with stop_sel=1 while tmr_busy is 0 raises cpu_stall and clears osc_en at the next clock edge. Both are restored on release.
- R4: A halt_req sampled with stop_sel=1 while tmr_busy is 1 keeps osc_en at 1 until tmr_busy is sampled 0. osc_en clears at that same edge, unless a release occurs at that edge.
- R5: Operand bits [1:0]=00 select the serial input. Operand bit 2 gives the level (1 = high, 0 = low). The release occurs 3 clock edges after the pin takes that level.
- R6: Operand bits [1:0]=01 select the key I/O lines. A release occurs 3 edges after any line takes the level set by bit 2, but only while kio_in_mode is 1. A rise of kio_in_mode with a line already at that level releases at the next edge.
- R7: Operand bits [1:0]=10 select the key input lines. A release occurs 3 edges after any line takes the level set by bit 2.
- R8: Operand bits [1:0]=11 select timer completion. A release occurs at the first edge that samples tmr_busy at 0. In stop mode, osc_en never clears when this release wins the same edge.
- R9: Operand bit 3 set to 1 (serial shift mode) releases standby at the edge after entry, whatever the pins show.
- R10: A release condition that is already true when halt is requested gives exactly one stalled cycle.
- R11: On release, wake_pulse is 1 for exactly one cycle, the same cycle in which cpu_stall returns to 0.
- R12: halt_req, rel_opnd and stop_sel are ignored while stalled. The captured operand and mode remain in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Halt strobe from the core |
| stop_sel | input | 1 | 1 = stop oscillator during standby |
| rel_opnd | input | 4 | Release operand: [3] always-release, [2] level, [1:0] source |
| tmr_busy | input | 1 | Burst timer down counter running |
| sin_pin | input | 1 | Serial input pin level |
| kio_pins | input | KIO_W | Key I/O pin levels |
| kio_in_mode | input | 1 | Key I/O lines are in input mode |
| ki_pins | input | KI_W | Key input pin levels |
| cpu_stall | output | 1 | Holds the core while in standby |
| osc_en | output | 1 | Oscillator enable |
| wake_pulse | output | 1 | One-cycle release indication |

## Verification
Each pin release is due on the third rising edge after the bench changes the pin: two synchronizer stages, then the state register. Control-level inputs (tmr_busy, kio_in_mode, always-release) act on the next edge. The bench drives every input at the falling edge and reads outputs at later falling edges. It counts the exact number of falling edges to each expected change and checks both the cycle before and the cycle of the change. For every source, both levels and every individual line, it confirms the inactive level holds standby and the active level releases exactly on time.

// File: rtl/stby_pkg.sv
package stby_pkg;
   localparam int OPND_W = 4;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_HALT  = 2'd1,
      ST_DEFER = 2'd2,
      ST_STOP  = 2'd3
   } stby_state_e;

   typedef enum logic [1:0] {
      SRC_SIN = 2'd0,
      SRC_KIO = 2'd1,
      SRC_KI  = 2'd2,
      SRC_TMR = 2'd3
   } stby_src_e;

   typedef struct packed {
      logic       force_rel;
      logic       lvl_high;
      stby_src_e  src;
   } stby_opnd_t;
endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
   parameter int W      = 13,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("stby_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("stby_sync: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/stby_wake_sel.sv
module stby_wake_sel
   import stby_pkg::*;
#(
   parameter int KIO_W = 8,
   parameter int KI_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stby_opnd_t       opnd_q,
   input  logic             sin_s,
   input  logic [KIO_W-1:0] kio_s,
   input  logic             kio_in_mode,
   input  logic [KI_W-1:0]  ki_s,
   input  logic             tmr_busy,
   output logic             wake_cond
);
   if (KIO_W < 1 || KI_W < 1) begin : g_bad_w
      $error("stby_wake_sel: line group widths must be positive");
   end

   logic sin_hit, kio_hit, ki_hit, tmr_hit;

   // level match per group, OR across the lines of a group
   always_comb begin
      if (opnd_q.lvl_high) begin
         sin_hit = sin_s;
         kio_hit = |kio_s;
         ki_hit  = |ki_s;
      end else begin
         sin_hit = ~sin_s;
         kio_hit = ~&kio_s;
         ki_hit  = ~&ki_s;
      end
      tmr_hit = ~tmr_busy;
   end

   always_comb begin
      if (opnd_q.force_rel) begin
         wake_cond = 1'b1;
      end else begin
         unique case (opnd_q.src)
            SRC_SIN: wake_cond = sin_hit;
            SRC_KIO: wake_cond = kio_hit & kio_in_mode;
            SRC_KI:  wake_cond = ki_hit;
            SRC_TMR: wake_cond = tmr_hit;
            default: wake_cond = 1'b0;
         endcase
      end
   end

   // R6: key I/O lines never release while they drive outputs
   p_kio_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!opnd_q.force_rel && opnd_q.src == SRC_KIO && !kio_in_mode) |-> !wake_cond);
   // R8: a running timer never satisfies the timer source
   p_tmr_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!opnd_q.force_rel && opnd_q.src == SRC_TMR && tmr_busy) |-> !wake_cond);
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
   import stby_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       halt_req,
   input  logic       stop_sel,
   input  stby_opnd_t opnd_in,
   input  logic       tmr_busy,
   input  logic       wake_cond,
   output stby_opnd_t opnd_q,
   output logic       cpu_stall,
   output logic       osc_en,
   output logic       wake_pulse
);
   stby_state_e st_q, st_d;
   logic        rel;

   assign rel = (st_q != ST_RUN) && wake_cond;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN: begin
            if (halt_req) begin
               if (!stop_sel)     st_d = ST_HALT;
               else if (tmr_busy) st_d = ST_DEFER;
               else               st_d = ST_STOP;
            end
         end
         ST_HALT:  if (rel) st_d = ST_RUN;
         ST_DEFER: begin
            if (rel)            st_d = ST_RUN;
            else if (!tmr_busy) st_d = ST_STOP;
         end
         ST_STOP:  if (rel) st_d = ST_RUN;
         default:  st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_RUN;
         opnd_q     <= '0;
         wake_pulse <= 1'b0;
      end else begin
         st_q       <= st_d;
         wake_pulse <= rel;
         if (st_q == ST_RUN && halt_req) opnd_q <= opnd_in;
      end
   end

   assign cpu_stall = (st_q != ST_RUN);
   assign osc_en    = (st_q != ST_STOP);

   // R2: halt strobe while running stalls at the next edge
   p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_stall && halt_req) |=> cpu_stall);
   // R2: halt without stop keeps the oscillator on
   p_halt_osc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_stall && halt_req && !stop_sel) |=> osc_en);
   // R4: oscillator only drops at an edge where the timer was idle
   p_stop_after_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_en && tmr_busy) |=> osc_en);
   // R9: forced release leaves after one stalled cycle
   p_force_rel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_stall && opnd_q.force_rel) |=> !cpu_stall);
   // R11: wake lasts one cycle
   p_pulse_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);
   // R11: wake coincides with leaving standby
   p_wake_ends_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (!cpu_stall && osc_en));
   // R12: operand frozen while stalled
   p_opnd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_stall) |=> $stable(opnd_q));
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
   import stby_pkg::*;
#(
   parameter int KIO_W       = 8,
   parameter int KI_W        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             halt_req,
   input  logic             stop_sel,
   input  logic [3:0]       rel_opnd,
   input  logic             tmr_busy,
   input  logic             sin_pin,
   input  logic [KIO_W-1:0] kio_pins,
   input  logic             kio_in_mode,
   input  logic [KI_W-1:0]  ki_pins,
   output logic             cpu_stall,
   output logic             osc_en,
   output logic             wake_pulse
);
   localparam int PIN_W = 1 + KIO_W + KI_W;

   logic [PIN_W-1:0] pins_raw, pins_s;
   stby_opnd_t       opnd_q;
   logic             wake_cond;

   assign pins_raw = {sin_pin, kio_pins, ki_pins};

   stby_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pins_raw),
      .q_sync  (pins_s)
   );

   stby_wake_sel #(.KIO_W(KIO_W), .KI_W(KI_W)) u_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .opnd_q      (opnd_q),
      .sin_s       (pins_s[PIN_W-1]),
      .kio_s       (pins_s[KI_W +: KIO_W]),
      .kio_in_mode (kio_in_mode),
      .ki_s        (pins_s[KI_W-1:0]),
      .tmr_busy    (tmr_busy),
      .wake_cond   (wake_cond)
   );

   stby_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt_req   (halt_req),
      .stop_sel   (stop_sel),
      .opnd_in    (stby_opnd_t'(rel_opnd)),
      .tmr_busy   (tmr_busy),
      .wake_cond  (wake_cond),
      .opnd_q     (opnd_q),
      .cpu_stall  (cpu_stall),
      .osc_en     (osc_en),
      .wake_pulse (wake_pulse)
   );
endmodule

// File: tb/stby_ctrl_test.sv
module stby_ctrl_test;
   localparam int KIO_W = 8;
   localparam int KI_W  = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             halt_req = 1'b0;
   logic             stop_sel = 1'b0;
   logic [3:0]       rel_opnd = 4'd0;
   logic             tmr_busy = 1'b0;
   logic             sin_pin = 1'b0;
   logic [KIO_W-1:0] kio_pins = '0;
   logic             kio_in_mode = 1'b1;
   logic [KI_W-1:0]  ki_pins = '0;
   logic             cpu_stall, osc_en, wake_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   stby_ctrl #(.KIO_W(KIO_W), .KI_W(KI_W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_sel(stop_sel),
      .rel_opnd(rel_opnd), .tmr_busy(tmr_busy), .sin_pin(sin_pin),
      .kio_pins(kio_pins), .kio_in_mode(kio_in_mode), .ki_pins(ki_pins),
      .cpu_stall(cpu_stall), .osc_en(osc_en), .wake_pulse(wake_pulse)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic outs(input string tag, input logic s, input logic o, input logic w);
      chk({tag, " stall"}, cpu_stall, s);
      chk({tag, " osc"}, osc_en, o);
      chk({tag, " wake"}, wake_pulse, w);
   endtask

   // strobe halt at a falling edge; returns one falling edge after entry
   task automatic enter(input logic [3:0] op, input logic mode);
      halt_req = 1'b1; rel_opnd = op; stop_sel = mode;
      tick(1);
      halt_req = 1'b0; rel_opnd = 4'd0; stop_sel = 1'b0;
   endtask

   task automatic set_idle(input logic pol);
      sin_pin  = ~pol;
      kio_pins = pol ? '0 : '1;
      ki_pins  = pol ? '0 : '1;
   endtask

   task automatic pin_case(input logic [1:0] src, input logic pol, input int idx, input string tag);
      set_idle(pol);
      kio_in_mode = 1'b1;
      tmr_busy = 1'b1;
      tick(3);
      enter({1'b0, pol, src}, 1'b0);
      outs({tag, " entry"}, 1'b1, 1'b1, 1'b0);
      tick(2);
      outs({tag, " idle hold"}, 1'b1, 1'b1, 1'b0);
      case (src)
         2'd0: sin_pin = pol;
         2'd1: kio_pins[idx] = pol;
         default: ki_pins[idx] = pol;
      endcase
      tick(2);
      outs({tag, " sync delay"}, 1'b1, 1'b1, 1'b0);
      tick(1);
      outs({tag, " release"}, 1'b0, 1'b1, 1'b1);
      tick(1);
      outs({tag, " R11 pulse end"}, 1'b0, 1'b1, 1'b0);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      outs("R1 reset", 1'b0, 1'b1, 1'b0);
      rst_n = 1'b1;
      tick(2);
      outs("R1 after reset", 1'b0, 1'b1, 1'b0);

      // R5 / R6 / R7 sweeps over level and line
      for (int p = 0; p < 2; p++) begin
         pin_case(2'd0, p[0], 0, "R5");
         for (int i = 0; i < KIO_W; i++) pin_case(2'd1, p[0], i, "R6");
         for (int i = 0; i < KI_W; i++)  pin_case(2'd2, p[0], i, "R7");
      end

      // R6: output mode blocks key I/O release until input mode returns
      set_idle(1'b1); kio_pins[3] = 1'b1; kio_in_mode = 1'b0; tmr_busy = 1'b1;
      tick(3);
      enter(4'b0101, 1'b0);
      tick(4);
      outs("R6 output mode hold", 1'b1, 1'b1, 1'b0);
      kio_in_mode = 1'b1;
      tick(1);
      outs("R6 input mode release", 1'b0, 1'b1, 1'b1);

      // R10: condition already true
      set_idle(1'b1); sin_pin = 1'b1;
      tick(3);
      enter(4'b0100, 1'b0);
      outs("R10 one stalled cycle", 1'b1, 1'b1, 1'b0);
      tick(1);
      outs("R10 release", 1'b0, 1'b1, 1'b1);

      // R9: forced release despite inactive pins
      set_idle(1'b1);
      tick(3);
      enter(4'b1100, 1'b0);
      outs("R9 entry", 1'b1, 1'b1, 1'b0);
      tick(1);
      outs("R9 release", 1'b0, 1'b1, 1'b1);

      // R3: stop with idle timer
      set_idle(1'b1); tmr_busy = 1'b0;
      tick(3);
      enter(4'b0100, 1'b1);
      outs("R3 stop entry", 1'b1, 1'b0, 1'b0);
      sin_pin = 1'b1;
      tick(2);
      outs("R3 stop hold", 1'b1, 1'b0, 1'b0);
      tick(1);
      outs("R3 stop release", 1'b0, 1'b1, 1'b1);

      // R4: stop deferred while timer runs
      set_idle(1'b1); tmr_busy = 1'b1;
      tick(3);
      enter(4'b0100, 1'b1);
      outs("R4 deferred", 1'b1, 1'b1, 1'b0);
      tick(3);
      outs("R4 still deferred", 1'b1, 1'b1, 1'b0);
      tmr_busy = 1'b0;
      tick(1);
      outs("R4 stop after zero", 1'b1, 1'b0, 1'b0);
      sin_pin = 1'b1;
      tick(3);
      outs("R4 release", 1'b0, 1'b1, 1'b1);

      // R8: timer source in halt mode
      set_idle(1'b1); tmr_busy = 1'b1;
      tick(3);
      enter(4'b0011, 1'b0);
      tick(2);
      outs("R8 halt busy", 1'b1, 1'b1, 1'b0);
      tmr_busy = 1'b0;
      tick(1);
      outs("R8 halt release", 1'b0, 1'b1, 1'b1);

      // R8: timer source in stop mode wins over stop entry
      tmr_busy = 1'b1;
      tick(2);
      enter(4'b0011, 1'b1);
      outs("R8 stop deferred", 1'b1, 1'b1, 1'b0);
      tmr_busy = 1'b0;
      tick(1);
      outs("R8 stop release", 1'b0, 1'b1, 1'b1);

      // R12: strobe while stalled is ignored
      set_idle(1'b1); tmr_busy = 1'b1;
      tick(3);
      enter(4'b0100, 1'b0);
      halt_req = 1'b1; rel_opnd = 4'b1000; stop_sel = 1'b1;
      tick(1);
      halt_req = 1'b0; rel_opnd = 4'd0; stop_sel = 1'b0;
      tick(2);
      outs("R12 ignored strobe", 1'b1, 1'b1, 1'b0);
      sin_pin = 1'b1;
      tick(3);
      outs("R12 original operand release", 1'b0, 1'b1, 1'b1);
      tick(1);
      outs("R11 idle after pulse", 1'b0, 1'b1, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule